// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block is the software-facing half of an I2C master. A simple 32-bit register bus reaches eight word-aligned registers: control, status, byte count, target address, a data port, the SCL divider, the data-delay setting and the stretch timeout. Two 16-byte FIFOs sit between the bus and a separate bit-level engine. Bytes written to the data port go into the transmit FIFO, where the engine takes them. Bytes that the engine collects go into the receive FIFO, where the bus reads them.

The block launches each transfer. It gives the engine a one-cycle start pulse together with the direction, byte count and target address. It also gives a one-cycle abort pulse when software cancels a read that is running. The engine reports completion, a missing acknowledge and a stretch timeout as single-cycle events. The status word merges those sticky events with live flags that come from the FIFO levels. One interrupt line is built from three enable bits.

Top module: `i2cm_regfile`

## Requirements
- R1: After reset the control, byte count (0x8), address (0xC) and data delay (0x18) registers read 0. The divider (0x14) reads 0x5DC and the stretch timeout (0x1C) reads 0x40. Status (0x4) reads 0x50, meaning both FIFOs are empty.
- R2: A bus write updates a register, and the value appears on the matching engine output. The widths are 16 bits for the byte count, 7 bits for the address, 16 bits for the divider, 32 bits for the delay and 16 bits for the timeout. Control keeps bits 0, 8, 9, 10 and 15. Read data is valid on `bus_rdata` in the cycle after `bus_rd`.
- R3: A write to offset 0x10 pushes the low byte into the transmit FIFO. `tx_data` shows the oldest byte while `tx_avail` is high. Each `tx_take` cycle removes one byte, in first-in first-out order.
- R4: Each `rx_push` cycle stores `rx_data` in the receive FIFO. A bus read of 0x10 returns the oldest stored byte and removes it.
- R5: A push into a full FIFO is dropped and leaves the FIFO's contents unchanged. A read of an empty receive FIFO returns 0 and leaves the level unchanged.
- R6: Writing control with bit 7 (start) and bit 15 (enable) both set does two things. It drives `eng_start` high for exactly the next cycle, and it sets status bit 0 (active). During that pulse `eng_read` equals control bit 0. Bit 7 written without bit 15 does nothing. Bit 7 always reads back as 0.
- R7: Status bit 4 is high while the transmit FIFO is not full. Bit 6 is high while the transmit FIFO is empty. Bit 5 is high while the receive FIFO holds data. Bit 7 is high while the receive FIFO is full.
- R8: Status bit 2 is high during an active write transfer while the transmit FIFO holds fewer than 4 bytes. Status bit 3 is high during an active read transfer while the receive FIFO holds 12 bytes or more.
- R9: The `ev_done` event sets status bit 1 and clears bit 0. `ev_nack` sets bit 8, and `ev_clkt` sets bit 9. Writing 1 to one of these bits clears it, and writing 0 has no effect. If an event and a clearing write arrive in the same cycle, the event wins.
- R10: A control write with bit 4 or bit 5 set empties both FIFOs.
- R11: Suppose a control write has bit 4 or bit 5 set and bit 15 clear, and a read transfer is active. Then `eng_abort` pulses for one cycle and status bit 0 clears. If a write transfer is active instead, no abort is issued.
- R12: `irq` is high exactly when one of three pairs is high together: control bit 8 and status bit 1, control bit 9 and status bit 2, or control bit 10 and status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle transfer launch |
| eng_abort | output | 1 | One-cycle read abort request |
| eng_read | output | 1 | Transfer direction, 1 for read |
| eng_len | output | 16 | Byte count |
| eng_saddr | output | 7 | Target address |
| eng_div | output | 16 | SCL divider |
| eng_delay | output | 32 | Data delay setting |
| eng_stretch | output | 16 | Stretch timeout |
| tx_data | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit FIFO not empty |
| tx_take | input | 1 | Engine takes one transmit byte |
| rx_data | input | 8 | Byte received by the engine |
| rx_push | input | 1 | Store `rx_data` in the receive FIFO |
| ev_done | input | 1 | Transfer completed |
| ev_nack | input | 1 | Acknowledge missing |
| ev_clkt | input | 1 | Stretch timeout expired |

## Verification
Every register, FIFO level and sticky bit changes at the clock edge that samples the strobe or event. Status flags and `irq` are combinational from that state, so they are valid in the cycle that follows. `eng_start` and `eng_abort` are high for exactly that one following cycle. A bus read puts its data on `bus_rdata` one edge after the strobe. The bench drives every stimulus on the falling edge and holds it across one rising edge. It checks results on the next falling edge. Pulse outputs are checked once more one cycle later to confirm that they have dropped.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT    = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_LEN     = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_SADDR   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_DATA    = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_DIV     = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_DELAY   = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_STRETCH = 5'h1C;

    localparam int C_RD    = 0;
    localparam int C_CLR0  = 4;
    localparam int C_CLR1  = 5;
    localparam int C_GO    = 7;
    localparam int C_IEDN  = 8;
    localparam int C_IETX  = 9;
    localparam int C_IERX  = 10;
    localparam int C_EN    = 15;

    localparam int S_DONE  = 1;
    localparam int S_NACK  = 8;
    localparam int S_TOUT  = 9;

    typedef struct packed {
        logic en;
        logic ie_rx;
        logic ie_tx;
        logic ie_done;
        logic rd;
    } ctrl_t;

    // Field order gives the status bit positions, bit 9 down to bit 0.
    typedef struct packed {
        logic tout;
        logic nack;
        logic rx_full;
        logic tx_empty;
        logic rx_any;
        logic tx_room;
        logic rx_need;
        logic tx_need;
        logic done;
        logic active;
    } stat_t;

    function automatic logic [31:0] ctrl_word(ctrl_t c);
        logic [31:0] w;
        w        = '0;
        w[C_RD]  = c.rd;
        w[C_IEDN] = c.ie_done;
        w[C_IETX] = c.ie_tx;
        w[C_IERX] = c.ie_rx;
        w[C_EN]  = c.en;
        return w;
    endfunction

endpackage

// File: rtl/i2cm_byte_fifo.sv
module i2cm_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            level <= level + CW'(do_push) - CW'(do_pop);
        end
    end

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/i2cm_status.sv
module i2cm_status
    import i2cm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int LOW  = DEPTH / 4,
    localparam int HIGH = (3 * DEPTH) / 4
) (
    input  ctrl_t         ctrl,
    input  logic          active,
    input  logic          done,
    input  logic          nack,
    input  logic          tout,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_level,
    output stat_t         stat,
    output logic          irq
);
    always_comb begin
        stat          = '0;
        stat.active   = active;
        stat.done     = done;
        stat.nack     = nack;
        stat.tout     = tout;
        stat.tx_room  = tx_level != CW'(DEPTH);
        stat.tx_empty = tx_level == '0;
        stat.rx_any   = rx_level != '0;
        stat.rx_full  = rx_level == CW'(DEPTH);
        stat.tx_need  = active && !ctrl.rd && (tx_level < CW'(LOW));
        stat.rx_need  = active && ctrl.rd && (rx_level >= CW'(HIGH));
    end

    assign irq = (ctrl.ie_done && stat.done) ||
                 (ctrl.ie_tx && stat.tx_need) ||
                 (ctrl.ie_rx && stat.rx_need);

endmodule

// File: rtl/i2cm_regfile.sv
module i2cm_regfile
    import i2cm_pkg::*;
#(
    parameter int          DEPTH       = 16,
    parameter logic [15:0] DIV_RST     = 16'h05DC,
    parameter logic [15:0] STRETCH_RST = 16'h0040,
    localparam int         CW          = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        eng_start,
    output logic        eng_abort,
    output logic        eng_read,
    output logic [15:0] eng_len,
    output logic [6:0]  eng_saddr,
    output logic [15:0] eng_div,
    output logic [31:0] eng_delay,
    output logic [15:0] eng_stretch,
    output logic [7:0]  tx_data,
    output logic        tx_avail,
    input  logic        tx_take,
    input  logic [7:0]  rx_data,
    input  logic        rx_push,
    input  logic        ev_done,
    input  logic        ev_nack,
    input  logic        ev_clkt
);
    ctrl_t         ctrl;
    stat_t         stat;
    logic          active, done, nack, tout;
    logic          wr_ctrl, wr_stat, flush, go, abort;
    logic [CW-1:0] tx_level, rx_level;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]    rx_head;

    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
    assign flush   = wr_ctrl && (bus_wdata[C_CLR0] || bus_wdata[C_CLR1]);
    assign go      = wr_ctrl && bus_wdata[C_GO] && bus_wdata[C_EN];
    assign abort   = flush && !bus_wdata[C_EN] && active && ctrl.rd;

    i2cm_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(bus_wr && (bus_addr == OFS_DATA)), .din(bus_wdata[7:0]),
        .pop(tx_take), .dout(tx_data), .level(tx_level),
        .full(tx_full), .empty(tx_empty)
    );

    i2cm_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(rx_push), .din(rx_data),
        .pop(bus_rd && (bus_addr == OFS_DATA)), .dout(rx_head), .level(rx_level),
        .full(rx_full), .empty(rx_empty)
    );

    i2cm_status #(.DEPTH(DEPTH)) u_stat (
        .ctrl(ctrl), .active(active), .done(done), .nack(nack), .tout(tout),
        .tx_level(tx_level), .rx_level(rx_level), .stat(stat), .irq(irq)
    );

    assign tx_avail = !tx_empty;
    assign eng_read = ctrl.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl        <= '0;
            active      <= 1'b0;
            done        <= 1'b0;
            nack        <= 1'b0;
            tout        <= 1'b0;
            eng_start   <= 1'b0;
            eng_abort   <= 1'b0;
            eng_len     <= '0;
            eng_saddr   <= '0;
            eng_div     <= DIV_RST;
            eng_delay   <= '0;
            eng_stretch <= STRETCH_RST;
            bus_rdata   <= '0;
        end else begin
            eng_start <= go;
            eng_abort <= abort;
            if (wr_ctrl) begin
                ctrl.rd      <= bus_wdata[C_RD];
                ctrl.ie_done <= bus_wdata[C_IEDN];
                ctrl.ie_tx   <= bus_wdata[C_IETX];
                ctrl.ie_rx   <= bus_wdata[C_IERX];
                ctrl.en      <= bus_wdata[C_EN];
            end
            if (go)                      active <= 1'b1;
            else if (ev_done || abort)   active <= 1'b0;
            if (ev_done)                           done <= 1'b1;
            else if (wr_stat && bus_wdata[S_DONE]) done <= 1'b0;
            if (ev_nack)                           nack <= 1'b1;
            else if (wr_stat && bus_wdata[S_NACK]) nack <= 1'b0;
            if (ev_clkt)                           tout <= 1'b1;
            else if (wr_stat && bus_wdata[S_TOUT]) tout <= 1'b0;
            if (bus_wr) begin
                case (bus_addr)
                    OFS_LEN:     eng_len     <= bus_wdata[15:0];
                    OFS_SADDR:   eng_saddr   <= bus_wdata[6:0];
                    OFS_DIV:     eng_div     <= bus_wdata[15:0];
                    OFS_DELAY:   eng_delay   <= bus_wdata;
                    OFS_STRETCH: eng_stretch <= bus_wdata[15:0];
                    default: ;
                endcase
            end
            if (bus_rd) begin
                case (bus_addr)
                    OFS_CTRL:    bus_rdata <= ctrl_word(ctrl);
                    OFS_STAT:    bus_rdata <= {22'b0, stat};
                    OFS_LEN:     bus_rdata <= {16'b0, eng_len};
                    OFS_SADDR:   bus_rdata <= {25'b0, eng_saddr};
                    OFS_DATA:    bus_rdata <= {24'b0, rx_head};
                    OFS_DIV:     bus_rdata <= {16'b0, eng_div};
                    OFS_DELAY:   bus_rdata <= eng_delay;
                    OFS_STRETCH: bus_rdata <= {16'b0, eng_stretch};
                    default:     bus_rdata <= '0;
                endcase
            end
        end
    end

    // R6
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> ($past(bus_wr) && $past(bus_wdata[C_EN]) && active));

    // R6
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start || $past(go));

    // R11
    abort_ends_chk: assert property (@(posedge clk) disable iff (rst)
        eng_abort |-> !active);

    // R9
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        ev_done |=> (stat.done && !stat.active) || $past(go));

    // R8
    need_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stat.tx_need && stat.rx_need));

    // R12
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.ie_done && !ctrl.ie_tx && !ctrl.ie_rx) |-> !irq);

endmodule

// File: tb/i2cm_regfile_bench.sv
module i2cm_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, eng_start, eng_abort, eng_read;
    logic [15:0] eng_len, eng_div, eng_stretch;
    logic [6:0]  eng_saddr;
    logic [31:0] eng_delay;
    logic [7:0]  tx_data;
    logic        tx_avail;
    logic        tx_take = 0;
    logic [7:0]  rx_data = '0;
    logic        rx_push = 0, ev_done = 0, ev_nack = 0, ev_clkt = 0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    i2cm_regfile u_i2cm_regfile (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_start(eng_start), .eng_abort(eng_abort),
        .eng_read(eng_read), .eng_len(eng_len), .eng_saddr(eng_saddr),
        .eng_div(eng_div), .eng_delay(eng_delay), .eng_stretch(eng_stretch),
        .tx_data(tx_data), .tx_avail(tx_avail), .tx_take(tx_take),
        .rx_data(rx_data), .rx_push(rx_push), .ev_done(ev_done),
        .ev_nack(ev_nack), .ev_clkt(ev_clkt)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [31:0] stat_exp(bit act, bit dn, int txn, int rxn, bit rdir);
        logic [31:0] s;
        s = '0;
        s[0] = act;
        s[1] = dn;
        s[2] = act && !rdir && (txn < 4);
        s[3] = act && rdir && (rxn >= 12);
        s[4] = txn < 16;
        s[5] = rxn > 0;
        s[6] = txn == 0;
        s[7] = rxn == 16;
        return s;
    endfunction

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset values
        rd(5'h00, v); check("R1 ctrl", v, 0);
        rd(5'h04, v); check("R1 status", v, 32'h50);
        rd(5'h08, v); check("R1 len", v, 0);
        rd(5'h0C, v); check("R1 saddr", v, 0);
        rd(5'h14, v); check("R1 div", v, 32'h5DC);
        rd(5'h18, v); check("R1 delay", v, 0);
        rd(5'h1C, v); check("R1 stretch", v, 32'h40);
        check("R1 irq", irq, 0);

        // R2 register sweep
        for (int i = 0; i < 8; i++) begin
            logic [31:0] p;
            p = (32'h9E37_79B9 * (i + 1)) ^ (32'h0F0F_0F0F << i);
            wr(5'h08, p); wr(5'h0C, p); wr(5'h14, p); wr(5'h18, p); wr(5'h1C, p);
            rd(5'h08, v); check("R2 len", v, p & 32'hFFFF);
            rd(5'h0C, v); check("R2 saddr", v, p & 32'h7F);
            rd(5'h14, v); check("R2 div", v, p & 32'hFFFF);
            rd(5'h18, v); check("R2 delay", v, p);
            rd(5'h1C, v); check("R2 stretch", v, p & 32'hFFFF);
            check("R2 eng_len", eng_len, p & 32'hFFFF);
            check("R2 eng_saddr", eng_saddr, p & 32'h7F);
            check("R2 eng_div", eng_div, p & 32'hFFFF);
            check("R2 eng_delay", eng_delay, p);
            check("R2 eng_stretch", eng_stretch, p & 32'hFFFF);
        end
        wr(5'h00, 32'h0701);
        rd(5'h00, v); check("R2 ctrl keeps bits", v, 32'h0701);
        wr(5'h00, 32'h0);

        // R6 start without enable ignored
        wr(5'h00, 32'h0080);
        check("R6 no start without enable", eng_start, 0);
        rd(5'h04, v); check("R6 inactive", v, 32'h50);

        // R6 write-direction start
        wr(5'h08, 32'd5); wr(5'h0C, 32'h2A);
        wr(5'h00, 32'h8280);
        check("R6 start pulse", eng_start, 1);
        check("R6 direction write", eng_read, 0);
        check("R6 len", eng_len, 5);
        check("R6 saddr", eng_saddr, 32'h2A);
        tick();
        check("R6 start one cycle", eng_start, 0);
        rd(5'h00, v); check("R6 start bit reads 0", v, 32'h8200);

        // R3 R7 R8 R12 transmit level sweep
        for (int n = 0; n < 18; n++) begin
            int c;
            c = (n > 16) ? 16 : n;
            rd(5'h04, v); check("R7 R8 tx status", v, stat_exp(1, 0, c, 0, 0));
            check("R12 irq tracks tx need", irq, c < 4);
            wr(5'h10, (n * 37 + 11) & 8'hFF);
        end
        for (int k = 0; k < 16; k++) begin
            check("R3 tx avail", tx_avail, 1);
            check("R3 R5 tx order", tx_data, (k * 37 + 11) & 8'hFF);
            @(negedge clk); tx_take = 1;
            @(negedge clk); tx_take = 0;
        end
        check("R3 tx drained", tx_avail, 0);

        // R9 done event and write-one-to-clear
        @(negedge clk); ev_done = 1;
        @(negedge clk); ev_done = 0;
        rd(5'h04, v); check("R9 done set active cleared", v, 32'h52);
        check("R12 no irq when done disabled", irq, 0);
        wr(5'h04, 32'h0);
        rd(5'h04, v); check("R9 write zero no effect", v, 32'h52);
        wr(5'h04, 32'h2);
        rd(5'h04, v); check("R9 done cleared", v, 32'h50);
        @(negedge clk); ev_nack = 1; ev_clkt = 1;
        @(negedge clk); ev_nack = 0; ev_clkt = 0;
        rd(5'h04, v); check("R9 nack and timeout set", v, 32'h350);
        wr(5'h04, 32'h100);
        rd(5'h04, v); check("R9 nack cleared", v, 32'h250);
        wr(5'h04, 32'h200);
        rd(5'h04, v); check("R9 timeout cleared", v, 32'h50);
        @(negedge clk);
        bus_wr = 1; bus_addr = 5'h04; bus_wdata = 32'h2; ev_done = 1;
        @(negedge clk);
        bus_wr = 0; ev_done = 0;
        rd(5'h04, v); check("R9 event beats clear", v, 32'h52);
        wr(5'h04, 32'h2);

        // R4 R5 R7 R8 R12 receive level sweep
        wr(5'h00, 32'h8481);
        check("R6 direction read", eng_read, 1);
        for (int n = 0; n < 18; n++) begin
            int c;
            c = (n > 16) ? 16 : n;
            rd(5'h04, v); check("R7 R8 rx status", v, stat_exp(1, 0, 0, c, 1));
            check("R12 irq tracks rx need", irq, c >= 12);
            @(negedge clk); rx_push = 1; rx_data = (n * 53 + 7) & 8'hFF;
            @(negedge clk); rx_push = 0;
        end
        for (int k = 0; k < 16; k++) begin
            rd(5'h10, v); check("R4 R5 rx order", v, (k * 53 + 7) & 8'hFF);
        end
        rd(5'h10, v); check("R5 empty pop zero", v, 0);
        rd(5'h04, v); check("R5 empty level kept", v, stat_exp(1, 0, 0, 0, 1));

        // R11 abort during read
        wr(5'h00, 32'h0010);
        check("R11 abort pulse", eng_abort, 1);
        tick();
        check("R11 abort one cycle", eng_abort, 0);
        rd(5'h04, v); check("R11 active cleared", v, 32'h50);

        // R10 R11 flush during write, no abort
        wr(5'h00, 32'h8080);
        wr(5'h10, 32'h1); wr(5'h10, 32'h2); wr(5'h10, 32'h3);
        @(negedge clk); rx_push = 1; rx_data = 8'h44;
        @(negedge clk); rx_data = 8'h55;
        @(negedge clk); rx_push = 0;
        rd(5'h04, v); check("R10 before flush", v, stat_exp(1, 0, 3, 2, 0));
        wr(5'h00, 32'h0020);
        check("R11 no abort in write", eng_abort, 0);
        rd(5'h04, v); check("R10 flushed", v, stat_exp(1, 0, 0, 0, 0));
        rd(5'h10, v); check("R10 rx empty after flush", v, 0);
        @(negedge clk); ev_done = 1;
        @(negedge clk); ev_done = 0;

        // R12 done interrupt
        wr(5'h00, 32'h0100);
        check("R12 irq on done", irq, 1);
        wr(5'h04, 32'h2);
        check("R12 irq drops", irq, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule